// File: doc/BRIEF.md
# Region Access Permission Checker

This block decides whether one bus access may proceed, given a set of region descriptors supplied by a neighbouring descriptor store. Each access carries an address, a master number, an access type (read, write or execute), a privilege mode (supervisor or user) and a process identifier. Each descriptor carries a start address, an end address, a valid bit, a packed rights word and a process identifier with an ignore mask.

The verdict is registered. A request presented in one cycle produces a verdict in the next cycle: allowed, or denied with a class that tells whether no region matched, one region matched and refused, or several matching regions all refused. Masters 0 to 3 hold full read/write/execute rights with a separate supervisor setting and an optional process-identifier qualifier. Masters 4 to 7 hold only read and write bits. When regions overlap, one permitting region is enough to allow the access. A global enable input turns checking off entirely.

Top module: `rgn_perm_chk`

## Requirements
- R1: A request on `req_i` produces `vld_o` high exactly one clock later; a cycle without a request gives `vld_o`, `deny_o` and `cls_o` all low in the next cycle.
- R2: With `en_i` low, every request is allowed: `deny_o` is 0 and `cls_o` is 0.
- R3: A region matches an address that is at or above its start address with bits 4:0 forced to 0 and at or below its end address with bits 4:0 forced to 1 (32-byte granularity).
- R4: A region whose valid bit is clear never matches; with no region valid, every enabled request is denied with class no-hit.
- R5: For masters 0 to 3 the rights word holds a 6-bit slot at bit `master*6`; bits 2:0 of the slot are the user rights with read=4, write=2, execute=1, and they apply in user mode (`sup_i`=0).
- R6: Bits 4:3 of a low-master slot are the supervisor setting used when `sup_i`=1: 0 gives read/write/execute, 1 read/execute, 2 read/write, 3 the user-mode rights.
- R7: For masters 4 to 7 the 2-bit field at bit `24+(master-4)*2` holds write in its bit 0 and read in its bit 1; execute by these masters is always denied.
- R8: Bit 5 of a low-master slot enables the process-identifier qualifier: the region then matches only if `pid_i` equals the region identifier on every bit whose mask bit is 0.
- R9: An access matching several regions is allowed if at least one matching region permits it.
- R10: `cls_o` encodes 0 allowed, 1 denied with no matching region, 2 denied by a single matching region, 3 denied with two or more matching regions; `deny_o` is 1 exactly when `cls_o` is non-zero.
- R11: `acc_i` encodes 0 read, 1 write, 2 execute; code 3 is never permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global checking enable |
| req_i | input | 1 | Access request present this cycle |
| addr_i | input | ADDR_W | Access address |
| mstr_i | input | 3 | Bus master number |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| sup_i | input | 1 | 1 for supervisor mode, 0 for user mode |
| pid_i | input | PID_W | Process identifier of the access |
| rgn_vld_i | input | N_RGN | Per-region valid bits |
| rgn_start_i | input | N_RGN*ADDR_W | Packed region start addresses, region 0 lowest |
| rgn_end_i | input | N_RGN*ADDR_W | Packed region end addresses |
| rgn_rights_i | input | N_RGN*32 | Packed region rights words |
| rgn_pid_i | input | N_RGN*PID_W | Packed region process identifiers |
| rgn_pidmsk_i | input | N_RGN*PID_W | Packed process identifier ignore masks |
| vld_o | output | 1 | Verdict valid |
| deny_o | output | 1 | Access denied |
| cls_o | output | 2 | Denial class |

## Verification
The hardest case to reach is an access that hits two regions where each region answers differently, because it needs two descriptors laid out to overlap on a chosen 32-byte block and rights chosen so that only one of them grants the tested type. The stimulus places a small region inside a larger one, then issues a write that only the inner region permits and an execute that neither permits, so that the allow-by-any rule and the overlap class are both seen. The process-identifier qualifier is reached by a region whose mask hides the low nibble, probed with identifiers that differ only inside and only outside the mask.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int MSTR_W    = 3;
  localparam int LO_CNT    = 4;
  localparam int LO_SLOT_W = 6;
  localparam int HI_BASE   = 24;
  localparam int HI_SLOT_W = 2;
  localparam int RIGHTS_W  = 32;
  localparam int GRAN_LSB  = 5;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_NOHIT   = 2'd1,
    CLS_SINGLE  = 2'd2,
    CLS_OVERLAP = 2'd3
  } cls_e;

  // rwx vector: bit2 read, bit1 write, bit0 execute
  function automatic logic [2:0] sup_rwx(input logic [1:0] fld, input logic [2:0] usr);
    case (fld)
      2'd0:    sup_rwx = 3'b111;
      2'd1:    sup_rwx = 3'b101;
      2'd2:    sup_rwx = 3'b110;
      default: sup_rwx = usr;
    endcase
  endfunction
endpackage

// File: rtl/rpc_rgn_match.sv
module rpc_rgn_match
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              vld_i,
  input  logic              pid_en_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [PID_W-1:0]  rgn_pid_i,
  input  logic [PID_W-1:0]  rgn_msk_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((64'd1 << GRAN_LSB) - 64'd1);

  logic [ADDR_W-1:0] lo_bnd, hi_bnd;
  logic              in_rng, pid_ok;

  always_comb begin
    lo_bnd = start_i & ~GRAN_MASK;
    hi_bnd = end_i | GRAN_MASK;
    in_rng = (addr_i >= lo_bnd) && (addr_i <= hi_bnd);
    pid_ok = !pid_en_i || (((pid_i ^ rgn_pid_i) & ~rgn_msk_i) == '0);
    hit_o  = vld_i && in_rng && pid_ok;
  end
endmodule

// File: rtl/rpc_rights_dec.sv
module rpc_rights_dec
  import rpc_pkg::*;
(
  input  logic [RIGHTS_W-1:0] rights_i,
  input  logic [MSTR_W-1:0]   mstr_i,
  input  logic [1:0]          acc_i,
  input  logic                sup_i,
  output logic                pid_en_o,
  output logic                perm_o
);
  localparam int IDX_W = $clog2(LO_CNT);

  logic [IDX_W-1:0]     idx;
  logic                 is_lo;
  logic [LO_SLOT_W-1:0] slot;
  logic [HI_SLOT_W-1:0] hi;
  logic [2:0]           rwx;

  always_comb begin
    idx   = mstr_i[IDX_W-1:0];
    is_lo = (int'(mstr_i) < LO_CNT);
    slot  = rights_i[int'(idx)*LO_SLOT_W +: LO_SLOT_W];
    hi    = rights_i[HI_BASE + int'(idx)*HI_SLOT_W +: HI_SLOT_W];
    if (is_lo) begin
      rwx      = sup_i ? sup_rwx(slot[4:3], slot[2:0]) : slot[2:0];
      pid_en_o = slot[5];
    end else begin
      rwx      = {hi[1], hi[0], 1'b0};
      pid_en_o = 1'b0;
    end
    case (acc_i)
      ACC_RD:  perm_o = rwx[2];
      ACC_WR:  perm_o = rwx[1];
      ACC_EX:  perm_o = rwx[0];
      default: perm_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rgn_perm_chk.sv
module rgn_perm_chk
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 8,
  parameter int N_RGN  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       req_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [2:0]                 mstr_i,
  input  logic [1:0]                 acc_i,
  input  logic                       sup_i,
  input  logic [PID_W-1:0]           pid_i,
  input  logic [N_RGN-1:0]           rgn_vld_i,
  input  logic [N_RGN*ADDR_W-1:0]    rgn_start_i,
  input  logic [N_RGN*ADDR_W-1:0]    rgn_end_i,
  input  logic [N_RGN*32-1:0]        rgn_rights_i,
  input  logic [N_RGN*PID_W-1:0]     rgn_pid_i,
  input  logic [N_RGN*PID_W-1:0]     rgn_pidmsk_i,
  output logic                       vld_o,
  output logic                       deny_o,
  output logic [1:0]                 cls_o
);
  logic [N_RGN-1:0] hit_v, ok_v, pe_v, perm_v;

  for (genvar r = 0; r < N_RGN; r++) begin : g_rgn
    rpc_rights_dec u_dec (
      .rights_i (rgn_rights_i[r*RIGHTS_W +: RIGHTS_W]),
      .mstr_i   (mstr_i),
      .acc_i    (acc_i),
      .sup_i    (sup_i),
      .pid_en_o (pe_v[r]),
      .perm_o   (perm_v[r])
    );
    rpc_rgn_match #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_match (
      .addr_i    (addr_i),
      .start_i   (rgn_start_i[r*ADDR_W +: ADDR_W]),
      .end_i     (rgn_end_i[r*ADDR_W +: ADDR_W]),
      .vld_i     (rgn_vld_i[r]),
      .pid_en_i  (pe_v[r]),
      .pid_i     (pid_i),
      .rgn_pid_i (rgn_pid_i[r*PID_W +: PID_W]),
      .rgn_msk_i (rgn_pidmsk_i[r*PID_W +: PID_W]),
      .hit_o     (hit_v[r])
    );
    assign ok_v[r] = hit_v[r] & perm_v[r];
  end

  logic multi, deny_d;
  cls_e cls_d;

  always_comb begin
    multi  = |(hit_v & (hit_v - 1'b1));
    deny_d = en_i && !(|ok_v);
    if (!deny_d)          cls_d = CLS_NONE;
    else if (hit_v == '0) cls_d = CLS_NOHIT;
    else if (multi)       cls_d = CLS_OVERLAP;
    else                  cls_d = CLS_SINGLE;
  end

  logic vld_q, deny_q;
  cls_e cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      deny_q <= 1'b0;
      cls_q  <= CLS_NONE;
    end else begin
      vld_q  <= req_i;
      deny_q <= req_i && deny_d;
      cls_q  <= req_i ? cls_d : CLS_NONE;
    end
  end

  assign vld_o  = vld_q;
  assign deny_o = deny_q;
  assign cls_o  = cls_q;
endmodule

// File: rtl/rpc_chk.sv
module rpc_chk
  import rpc_pkg::*;
#(
  parameter int N_RGN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             req_i,
  input logic [2:0]       mstr_i,
  input logic [1:0]       acc_i,
  input logic [N_RGN-1:0] rgn_vld_i,
  input logic             vld_o,
  input logic             deny_o,
  input logic [1:0]       cls_o
);
  // R1
  req_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) req_i |=> vld_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!vld_o && !deny_o && cls_o == CLS_NONE));
  // R2
  dis_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !en_i) |=> (!deny_o && cls_o == CLS_NONE));
  // R4
  no_vld_nohit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i && rgn_vld_i == '0) |=> (deny_o && cls_o == CLS_NOHIT));
  // R7
  hi_noexec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i && acc_i == ACC_EX && mstr_i[2]) |=> deny_o);
  // R11
  rsv_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i && acc_i == ACC_RSV) |=> deny_o);
  // R10
  cls_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o == (cls_o != CLS_NONE));
endmodule

bind rgn_perm_chk rpc_chk #(.N_RGN(N_RGN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .req_i     (req_i),
  .mstr_i    (mstr_i),
  .acc_i     (acc_i),
  .rgn_vld_i (rgn_vld_i),
  .vld_o     (vld_o),
  .deny_o    (deny_o),
  .cls_o     (cls_o)
);

// File: tb/sim_rgn_perm_chk.sv
`timescale 1ns/1ps
module sim_rgn_perm_chk;
  import rpc_pkg::*;
  localparam int AW = 32;
  localparam int PW = 8;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, req = 1'b0, sup = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0] mstr = '0;
  logic [1:0] acc = '0;
  logic [PW-1:0] pid = '0;
  logic [NR-1:0] rvld = '0;
  logic [NR*AW-1:0] rstart = '0, rend = '0;
  logic [NR*32-1:0] rrights = '0;
  logic [NR*PW-1:0] rpid = '0, rmsk = '0;
  logic vld, deny;
  logic [1:0] cls;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rgn_perm_chk #(.ADDR_W(AW), .PID_W(PW), .N_RGN(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .req_i(req), .addr_i(addr),
    .mstr_i(mstr), .acc_i(acc), .sup_i(sup), .pid_i(pid), .rgn_vld_i(rvld),
    .rgn_start_i(rstart), .rgn_end_i(rend), .rgn_rights_i(rrights),
    .rgn_pid_i(rpid), .rgn_pidmsk_i(rmsk), .vld_o(vld), .deny_o(deny), .cls_o(cls)
  );

  task automatic acc_chk(input string tag, input logic [AW-1:0] a, input logic [2:0] m,
                         input logic [1:0] t, input logic s, input logic [PW-1:0] p,
                         input logic exp_d, input logic [1:0] exp_c);
    @(negedge clk);
    req = 1'b1; addr = a; mstr = m; acc = t; sup = s; pid = p;
    @(negedge clk);
    req = 1'b0;
    n_run++;
    if (vld !== 1'b1 || deny !== exp_d || cls !== exp_c) begin
      n_fail++;
      $display("FAIL %s: vld=%0b deny=%0b cls=%0d expected vld=1 deny=%0b cls=%0d",
               tag, vld, deny, cls, exp_d, exp_c);
    end
  endtask

  task automatic t_reset;
    n_run++;
    if (vld !== 1'b0 || deny !== 1'b0 || cls !== 2'd0) begin
      n_fail++;
      $display("FAIL R1 reset: vld=%0b deny=%0b cls=%0d expected 0 0 0", vld, deny, cls);
    end
  endtask

  task automatic t_idle;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    n_run++;
    if (vld !== 1'b0 || deny !== 1'b0 || cls !== 2'd0) begin
      n_fail++;
      $display("FAIL R1 idle: vld=%0b deny=%0b cls=%0d expected 0 0 0", vld, deny, cls);
    end
  endtask

  task automatic t_novalid;
    acc_chk("R4 no valid region", 32'h1000, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b1, CLS_NOHIT);
  endtask

  task automatic setup_regions;
    // region0: 0x1000-0x1FFF, m0 user read, supervisor same as user
    rstart[0*AW +: AW] = 32'h1000; rend[0*AW +: AW] = 32'h1FFF;
    rrights[0*32 +: 32] = 32'h0000_001C;
    // region1: unaligned bounds -> 0x2000-0x201F
    rstart[1*AW +: AW] = 32'h2005; rend[1*AW +: AW] = 32'h2000;
    rrights[1*32 +: 32] = 32'h0B01_0207;
    // region2: 0x1800-0x18FF, m0 user write, supervisor same as user
    rstart[2*AW +: AW] = 32'h1800; rend[2*AW +: AW] = 32'h18FF;
    rrights[2*32 +: 32] = 32'h0000_001A;
    // region3: 0x8000-0x8FFF, m0 full, m3 full with pid qualifier
    rstart[3*AW +: AW] = 32'h8000; rend[3*AW +: AW] = 32'h8FFF;
    rrights[3*32 +: 32] = 32'h00FC_0007;
    rpid[3*PW +: PW] = 8'h5A; rmsk[3*PW +: PW] = 8'h0F;
    rvld = 4'b0111;
  endtask

  task automatic t_match;
    acc_chk("R3 aligned start", 32'h2000, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R3 end rounded up", 32'h201F, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R3 past end", 32'h2020, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b1, CLS_NOHIT);
    acc_chk("R3 region0 last byte", 32'h1FFF, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b0, CLS_NONE);
  endtask

  task automatic t_user;
    acc_chk("R5 user write refused", 32'h1000, 3'd0, ACC_WR, 1'b0, 8'h0, 1'b1, CLS_SINGLE);
    acc_chk("R5 user exec refused", 32'h1000, 3'd0, ACC_EX, 1'b0, 8'h0, 1'b1, CLS_SINGLE);
    acc_chk("R5 m1 user read none", 32'h2000, 3'd1, ACC_RD, 1'b0, 8'h0, 1'b1, CLS_SINGLE);
    acc_chk("R11 reserved type", 32'h2000, 3'd0, ACC_RSV, 1'b0, 8'h0, 1'b1, CLS_SINGLE);
  endtask

  task automatic t_sup;
    acc_chk("R6 sup=3 follows user read", 32'h1000, 3'd0, ACC_RD, 1'b1, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R6 sup=3 follows user write", 32'h1000, 3'd0, ACC_WR, 1'b1, 8'h0, 1'b1, CLS_SINGLE);
    acc_chk("R6 sup=1 exec", 32'h2000, 3'd1, ACC_EX, 1'b1, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R6 sup=1 write", 32'h2000, 3'd1, ACC_WR, 1'b1, 8'h0, 1'b1, CLS_SINGLE);
    acc_chk("R6 sup=2 write", 32'h2000, 3'd2, ACC_WR, 1'b1, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R6 sup=2 exec", 32'h2000, 3'd2, ACC_EX, 1'b1, 8'h0, 1'b1, CLS_SINGLE);
    acc_chk("R6 sup=0 exec", 32'h2000, 3'd0, ACC_EX, 1'b1, 8'h0, 1'b0, CLS_NONE);
  endtask

  task automatic t_hi;
    acc_chk("R7 m5 read", 32'h2000, 3'd5, ACC_RD, 1'b0, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R7 m5 write", 32'h2000, 3'd5, ACC_WR, 1'b0, 8'h0, 1'b1, CLS_SINGLE);
    acc_chk("R7 m4 write", 32'h2000, 3'd4, ACC_WR, 1'b1, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R7 m4 exec", 32'h2000, 3'd4, ACC_EX, 1'b1, 8'h0, 1'b1, CLS_SINGLE);
  endtask

  task automatic t_overlap;
    acc_chk("R9 overlap one permits", 32'h1800, 3'd0, ACC_WR, 1'b0, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R10 overlap all refuse", 32'h1800, 3'd0, ACC_EX, 1'b0, 8'h0, 1'b1, CLS_OVERLAP);
  endtask

  task automatic t_invalid;
    acc_chk("R4 invalid region", 32'h8000, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b1, CLS_NOHIT);
    rvld = 4'b1111;
    acc_chk("R4 region now valid", 32'h8000, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b0, CLS_NONE);
  endtask

  task automatic t_pid;
    acc_chk("R8 pid masked match", 32'h8100, 3'd3, ACC_WR, 1'b0, 8'h53, 1'b0, CLS_NONE);
    acc_chk("R8 pid mismatch", 32'h8100, 3'd3, ACC_WR, 1'b0, 8'h63, 1'b1, CLS_NOHIT);
    acc_chk("R8 pid ignored when off", 32'h8100, 3'd0, ACC_WR, 1'b0, 8'h63, 1'b0, CLS_NONE);
  endtask

  task automatic t_disable;
    en = 1'b0;
    acc_chk("R2 disabled no hit", 32'h3000, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b0, CLS_NONE);
    acc_chk("R2 disabled refused", 32'h2000, 3'd4, ACC_EX, 1'b0, 8'h0, 1'b0, CLS_NONE);
    en = 1'b1;
    acc_chk("R2 re-enabled", 32'h3000, 3'd0, ACC_RD, 1'b0, 8'h0, 1'b1, CLS_NOHIT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_novalid();
    setup_regions();
    t_match();
    t_user();
    t_sup();
    t_hi();
    t_overlap();
    t_invalid();
    t_pid();
    t_disable();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected finish before 20000 cycles");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule